// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit input vectors by a square weight matrix. The matrix is held inside a grid of multiply-accumulate cells. The matrix is loaded first, one row per beat. The beats shift down the columns of the grid, and once every row has arrived the block raises a ready flag and begins to accept input vectors.

Each accepted vector enters the left edge of the grid with a diagonal skew, so that grid row i sees its element i cycles later than row 0. Activations travel to the right and partial sums travel downward. At the bottom edge the column results are realigned into one complete output row. That row is then written into a small bank of 32-bit accumulators, either replacing the addressed row or adding to it.

Input vectors can be presented on every cycle. After the first result has passed through the pipeline, one result row is retired per cycle. A clear control wipes the whole bank. Software reads the bank through a combinational read port.

Top module: `wsSystolicMatmul`

## Requirements
- R1: After reset `loadDone`, `inReady` and `resValid` are 0, and every accumulator row reads back as zero.
- R2: A weight load is N beats of `wValid`. Beat k (counting from 0) carries weight row N-1-k, with element c in bits [8c+7:8c]. `loadDone` goes high in the cycle after the N-th beat. A beat that arrives while `loadDone` is high starts a new load and drops `loadDone` in the next cycle.
- R3: `inReady` equals `loadDone`. A vector is taken only in a cycle where both `inValid` and `inReady` are high. A vector offered while `inReady` is low produces no result and leaves every accumulator row unchanged.
- R4: For input x, where element i sits in `inRow` bits [8i+7:8i], output column j is the signed sum over i of x[i]*W[i][j], computed in 32-bit two's complement.
- R5: `resValid` is high exactly 2N-1 cycles after the cycle in which the vector was accepted. The accumulator row holds the new value from the next cycle on.
- R6: Vectors accepted on consecutive cycles retire on consecutive cycles, one row per cycle, in the order they were accepted.
- R7: With `accMode`=0 sampled alongside the vector, the addressed accumulator row is replaced by the result.
- R8: With `accMode`=1, the result is added column by column to the addressed row, wrapping modulo 2^32.
- R9: `clearAcc` zeros every accumulator row in the next cycle. It takes priority over a result written in the same cycle.
- R10: The result is stored at the row given by `inAddr` at acceptance. `rdData` shows row `rdAddr` combinationally, with column j in bits [32j+31:32j].
- R11: The loaded weights stay in place across any number of input vectors, so batches need no reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wValid | input | 1 | Weight row beat strobe |
| wRow | input | N*8 | Weight row data, element c at [8c+7:8c] |
| loadDone | output | 1 | All N weight rows are in place |
| inValid | input | 1 | Input vector offered |
| inReady | output | 1 | Block accepts input vectors |
| inRow | input | N*8 | Input vector, element i at [8i+7:8i] |
| inAddr | input | $clog2(ACC_ROWS) | Accumulator row targeted by this vector |
| accMode | input | 1 | 1 adds to the row, 0 replaces it |
| clearAcc | input | 1 | Zero the whole accumulator bank |
| resValid | output | 1 | A result row is written this cycle |
| rdAddr | input | $clog2(ACC_ROWS) | Accumulator read row |
| rdData | output | N*32 | Contents of row rdAddr, column j at [32j+31:32j] |

## Verification
The multiply is tried with a fixed table of vectors that contains the extreme codes -128 and 127, mixed signs, a single nonzero element and a counting pattern. These are run against a weight matrix that also holds both extremes, so sign-extension and lane-ordering errors show up as wrong columns. The same table is then replayed in accumulate mode to separate adding from overwriting. Unpredictable vectors follow, and afterwards a second weight matrix, to show that the weights stay resident and that a reload really replaces them. A clear timed to hit the same edge as a result write decides the priority between the two. A vector offered before any weights are loaded confirms that nothing is taken in.

// File: rtl/wsMatPkg.sv
package wsMatPkg;
  typedef struct packed {
    logic shiftW;
    logic feed;
    logic wrEn;
    logic wrAccum;
    logic clearAll;
  } wsStrobes_t;
endpackage

// File: rtl/wsMacCell.sv
module wsMacCell #(
  parameter int DW = 8,
  parameter int SW = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] aIn,
  input  logic signed [DW-1:0] wIn,
  input  logic signed [SW-1:0] pIn,
  output logic signed [SW-1:0] pOut
);
  localparam int PW = 2 * DW;
  logic signed [PW-1:0] prod;
  assign prod = aIn * wIn;

  always_ff @(posedge clk) begin
    if (!rstN) pOut <= '0;
    else       pOut <= pIn + {{(SW-PW){prod[PW-1]}}, prod};
  end
endmodule

// File: rtl/wsArrayCtrl.sv
module wsArrayCtrl
  import wsMatPkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wValid,
  input  logic          inValid,
  input  logic [AW-1:0] inAddr,
  input  logic          accMode,
  input  logic          clearAcc,
  output wsStrobes_t    st,
  output logic [AW-1:0] wrAddr,
  output logic          loadDone,
  output logic          inReady,
  output logic          resValid
);
  localparam int LAT = 2 * N - 1;
  localparam int CW  = (N > 2) ? $clog2(N) : 1;

  logic [CW-1:0] loadCnt;
  logic          vPipe [LAT];
  logic [AW-1:0] addrPipe [LAT];
  logic          modePipe [LAT];
  logic          accept;

  assign accept  = inValid && loadDone;
  assign inReady = loadDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt  <= '0;
      loadDone <= 1'b0;
    end else if (wValid) begin
      if (loadDone) begin
        loadCnt  <= CW'(1);
        loadDone <= 1'b0;
      end else if (loadCnt == CW'(N - 1)) begin
        loadCnt  <= '0;
        loadDone <= 1'b1;
      end else begin
        loadCnt <= loadCnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < LAT; k++) begin
        vPipe[k]    <= 1'b0;
        addrPipe[k] <= '0;
        modePipe[k] <= 1'b0;
      end
    end else begin
      vPipe[0]    <= accept;
      addrPipe[0] <= inAddr;
      modePipe[0] <= accMode;
      for (int k = 1; k < LAT; k++) begin
        vPipe[k]    <= vPipe[k-1];
        addrPipe[k] <= addrPipe[k-1];
        modePipe[k] <= modePipe[k-1];
      end
    end
  end

  always_comb begin
    st.shiftW   = wValid;
    st.feed     = accept;
    st.wrEn     = vPipe[LAT-1];
    st.wrAccum  = modePipe[LAT-1];
    st.clearAll = clearAcc;
  end
  assign wrAddr   = addrPipe[LAT-1];
  assign resValid = vPipe[LAT-1];

  // R2: the ready flag only comes up right after a weight beat
  assert_load_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> $past(wValid));
  // R3: a beat during a finished load drops the flag
  assert_reload_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && loadDone) |=> !inReady);
endmodule

// File: rtl/wsArrayDatapath.sv
module wsArrayDatapath
  import wsMatPkg::*;
#(
  parameter int N    = 4,
  parameter int DW   = 8,
  parameter int SW   = 32,
  parameter int ROWS = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  wsStrobes_t      st,
  input  logic [AW-1:0]   wrAddr,
  input  logic [N*DW-1:0] wRowIn,
  input  logic [N*DW-1:0] inRow,
  input  logic [AW-1:0]   rdAddr,
  output logic [N*SW-1:0] rdData
);
  logic signed [DW-1:0] wReg   [N][N];
  logic signed [DW-1:0] skewOut[N];
  logic signed [DW-1:0] aInNet [N][N];
  logic signed [DW-1:0] aReg   [N][N-1];
  logic signed [SW-1:0] pNet   [N][N];
  logic signed [SW-1:0] resRow [N];
  logic signed [SW-1:0] tgtRow [N];
  logic signed [SW-1:0] acc    [ROWS][N];

  // weight rows shift downward, one row per beat
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) wReg[r][c] <= '0;
    end else if (st.shiftW) begin
      for (int c = 0; c < N; c++) begin
        wReg[0][c] <= wRowIn[c*DW +: DW];
        for (int r = 1; r < N; r++) wReg[r][c] <= wReg[r-1][c];
      end
    end
  end

  // diagonal skew at the left edge: row r is delayed r cycles
  for (genvar r = 0; r < N; r++) begin : gSkew
    logic signed [DW-1:0] feedElem;
    assign feedElem = st.feed ? inRow[r*DW +: DW] : '0;
    if (r == 0) begin : gNoDelay
      assign skewOut[r] = feedElem;
    end else begin : gDelay
      logic signed [DW-1:0] sq [r];
      always_ff @(posedge clk) begin
        if (!rstN) for (int k = 0; k < r; k++) sq[k] <= '0;
        else begin
          sq[0] <= feedElem;
          for (int k = 1; k < r; k++) sq[k] <= sq[k-1];
        end
      end
      assign skewOut[r] = sq[r-1];
    end
  end

  // grid of cells
  for (genvar r = 0; r < N; r++) begin : gRow
    for (genvar c = 0; c < N; c++) begin : gCol
      logic signed [SW-1:0] pInLocal;
      if (c == 0) begin : gEdgeA
        assign aInNet[r][c] = skewOut[r];
      end else begin : gInnerA
        assign aInNet[r][c] = aReg[r][c-1];
      end
      if (c < N - 1) begin : gPassA
        always_ff @(posedge clk) begin
          if (!rstN) aReg[r][c] <= '0;
          else       aReg[r][c] <= aInNet[r][c];
        end
      end
      if (r == 0) begin : gTopP
        assign pInLocal = '0;
      end else begin : gInnerP
        assign pInLocal = pNet[r-1][c];
      end
      wsMacCell #(.DW(DW), .SW(SW)) u_cell (
        .clk(clk), .rstN(rstN),
        .aIn(aInNet[r][c]), .wIn(wReg[r][c]),
        .pIn(pInLocal), .pOut(pNet[r][c])
      );
    end
  end

  // realign the bottom edge: column j waits N-1-j cycles
  for (genvar j = 0; j < N; j++) begin : gDeskew
    localparam int D = N - 1 - j;
    if (D == 0) begin : gNoDelay
      assign resRow[j] = pNet[N-1][j];
    end else begin : gDelay
      logic signed [SW-1:0] dq [D];
      always_ff @(posedge clk) begin
        if (!rstN) for (int k = 0; k < D; k++) dq[k] <= '0;
        else begin
          dq[0] <= pNet[N-1][j];
          for (int k = 1; k < D; k++) dq[k] <= dq[k-1];
        end
      end
      assign resRow[j] = dq[D-1];
    end
  end

  // accumulator bank
  always_ff @(posedge clk) begin
    if (!rstN || st.clearAll) begin
      for (int a = 0; a < ROWS; a++)
        for (int j = 0; j < N; j++) acc[a][j] <= '0;
    end else if (st.wrEn) begin
      for (int j = 0; j < N; j++)
        acc[wrAddr][j] <= (st.wrAccum ? acc[wrAddr][j] : '0) + resRow[j];
    end
  end

  for (genvar j = 0; j < N; j++) begin : gRead
    assign tgtRow[j]           = acc[wrAddr][j];
    assign rdData[j*SW +: SW]  = acc[rdAddr][j];

    // R7: overwrite replaces the addressed row
    assert_overwrite_R7: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrEn && !st.wrAccum && !st.clearAll)
        |=> acc[$past(wrAddr)][j] == $past(resRow[j]));
    // R8: accumulate adds to the previous contents
    assert_accumulate_R8: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrEn && st.wrAccum && !st.clearAll)
        |=> acc[$past(wrAddr)][j] == $past(tgtRow[j]) + $past(resRow[j]));
  end

  for (genvar a = 0; a < ROWS; a++) begin : gClrChk
    // R9: clear wins over everything
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      st.clearAll |=> (acc[a][0] == '0) && (acc[a][N-1] == '0));
  end
endmodule

// File: rtl/wsSystolicMatmul.sv
module wsSystolicMatmul
  import wsMatPkg::*;
#(
  parameter int N        = 4,
  parameter int ACC_ROWS = 8,
  localparam int DW      = 8,
  localparam int SW      = 32,
  localparam int AW      = (ACC_ROWS > 1) ? $clog2(ACC_ROWS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wValid,
  input  logic [N*DW-1:0] wRow,
  output logic            loadDone,
  input  logic            inValid,
  output logic            inReady,
  input  logic [N*DW-1:0] inRow,
  input  logic [AW-1:0]   inAddr,
  input  logic            accMode,
  input  logic            clearAcc,
  output logic            resValid,
  input  logic [AW-1:0]   rdAddr,
  output logic [N*SW-1:0] rdData
);
  wsStrobes_t    st;
  logic [AW-1:0] wrAddr;

  wsArrayCtrl #(.N(N), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wValid(wValid), .inValid(inValid),
    .inAddr(inAddr), .accMode(accMode), .clearAcc(clearAcc),
    .st(st), .wrAddr(wrAddr), .loadDone(loadDone),
    .inReady(inReady), .resValid(resValid)
  );

  wsArrayDatapath #(.N(N), .DW(DW), .SW(SW), .ROWS(ACC_ROWS), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrAddr(wrAddr),
    .wRowIn(wRow), .inRow(inRow), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/wsSystolicMatmul_bench.sv
`timescale 1ns/1ps
module wsSystolicMatmul_bench;
  localparam int N    = 4;
  localparam int ROWS = 8;
  localparam int LAT  = 2 * N - 1;

  localparam logic [N*8-1:0] STIM [8] = '{
    32'h01020304, 32'h80808080, 32'h7F7F7F7F, 32'hFF01FF01,
    32'h807F807F, 32'h00000001, 32'h12345678, 32'hC0DE0B05
  };

  logic clk = 0;
  logic rstN = 0;
  logic wValid = 0;
  logic [N*8-1:0] wRow = '0;
  logic loadDone, inReady, resValid;
  logic inValid = 0;
  logic [N*8-1:0] inRow = '0;
  logic [2:0] inAddr = '0;
  logic accMode = 0;
  logic clearAcc = 0;
  logic [2:0] rdAddr = '0;
  logic [N*32-1:0] rdData;

  always #2 clk = ~clk;

  wsSystolicMatmul #(.N(N), .ACC_ROWS(ROWS)) u_wsSystolicMatmul (
    .clk(clk), .rstN(rstN), .wValid(wValid), .wRow(wRow), .loadDone(loadDone),
    .inValid(inValid), .inReady(inReady), .inRow(inRow), .inAddr(inAddr),
    .accMode(accMode), .clearAcc(clearAcc), .resValid(resValid),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int resCount = 0;
  int firstResCyc = 0;
  int lastResCyc = 0;
  bit finished = 0;
  logic signed [7:0] wMat [N][N];
  logic [N*32-1:0] expAcc [ROWS];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (resValid) begin
      if (resCount == 0) firstResCyc = cyc;
      lastResCyc = cyc;
      resCount++;
    end
  end

  task automatic chk(input string req, input logic [N*32-1:0] act, input logic [N*32-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [N*32-1:0] refRow(input logic [N*8-1:0] x);
    logic [N*32-1:0] r;
    for (int j = 0; j < N; j++) begin
      logic signed [31:0] s = 0;
      for (int i = 0; i < N; i++)
        s += 32'($signed(x[8*i +: 8])) * 32'(wMat[i][j]);
      r[32*j +: 32] = s;
    end
    return r;
  endfunction

  function automatic logic [N*32-1:0] addRows(input logic [N*32-1:0] a, input logic [N*32-1:0] b);
    logic [N*32-1:0] r;
    for (int j = 0; j < N; j++) r[32*j +: 32] = a[32*j +: 32] + b[32*j +: 32];
    return r;
  endfunction

  task automatic setWeights(input int variant);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        wMat[r][c] = 8'((r * N + c) * (variant == 0 ? 37 : 53) + 11 + variant * 90);
    wMat[0][0] = -128;
    wMat[N-1][N-1] = 127;
  endtask

  task automatic loadWeights(input bit expectDrop);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      if (k == 1 && expectDrop) chk("R2 loadDone drops on reload", 128'(loadDone), 128'(0));
      if (k > 0) chk("R2 loadDone low mid-load", 128'(loadDone), 128'(0));
      wValid = 1;
      for (int c = 0; c < N; c++) wRow[8*c +: 8] = wMat[N-1-k][c];
    end
    @(negedge clk);
    wValid = 0;
    chk("R2 loadDone after N beats", 128'(loadDone), 128'(1));
    chk("R3 inReady follows loadDone", 128'(inReady), 128'(1));
  endtask

  task automatic readRow(input int a, input string req);
    @(negedge clk);
    rdAddr = 3'(a);
    #1;
    chk(req, rdData, expAcc[a]);
  endtask

  task automatic runBatch(input int n, input bit mode, input int base, input bit useRand, input string req);
    int c0 = 0;
    resCount = 0;
    for (int i = 0; i < n; i++) begin
      logic [N*8-1:0] v;
      @(negedge clk);
      if (i == 0) c0 = cyc;
      v = useRand ? $urandom : STIM[i];
      inValid = 1;
      inRow = v;
      inAddr = 3'(base + i);
      accMode = mode;
      expAcc[(base + i) % ROWS] = mode ? addRows(expAcc[(base + i) % ROWS], refRow(v)) : refRow(v);
    end
    @(negedge clk);
    inValid = 0;
    repeat (LAT + 2) @(negedge clk);
    chk("R6 one result per accepted vector", 128'(resCount), 128'(n));
    chk("R5 latency 2N-1", 128'(firstResCyc - c0), 128'(LAT));
    chk("R6 consecutive retire", 128'(lastResCyc - firstResCyc), 128'(n - 1));
    for (int i = 0; i < n; i++) readRow((base + i) % ROWS, req);
  endtask

  initial begin
    for (int a = 0; a < ROWS; a++) expAcc[a] = '0;
    setWeights(0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 loadDone reset", 128'(loadDone), 128'(0));
    chk("R1 inReady reset", 128'(inReady), 128'(0));
    chk("R1 resValid reset", 128'(resValid), 128'(0));
    for (int a = 0; a < ROWS; a++) readRow(a, "R1 accumulator zero");

    // R3: offered before weights exist, must be ignored
    resCount = 0;
    @(negedge clk);
    inValid = 1; inRow = STIM[1]; inAddr = 3'd2; accMode = 0;
    @(negedge clk);
    inValid = 0;
    repeat (LAT + 2) @(negedge clk);
    chk("R3 no result while not ready", 128'(resCount), 128'(0));
    readRow(2, "R3 row untouched while not ready");

    loadWeights(0);
    // R4 R7 R10: table in overwrite mode
    runBatch(8, 0, 0, 0, "R4 R10 table overwrite");
    // R8: same table accumulated
    runBatch(8, 1, 0, 0, "R8 table accumulate");
    // R7: overwrite after accumulate
    runBatch(2, 0, 3, 1, "R7 overwrite replaces");
    // R11: further random batch without reload
    runBatch(6, 1, 1, 1, "R11 weights stay resident");

    // R9: clear lands on the same edge as a write
    @(negedge clk);
    inValid = 1; inRow = STIM[2]; inAddr = 3'd6; accMode = 1;
    @(negedge clk);
    inValid = 0;
    for (int t = 0; t < 4 * N && !resValid; t++) @(negedge clk);
    clearAcc = 1;
    @(negedge clk);
    clearAcc = 0;
    for (int a = 0; a < ROWS; a++) expAcc[a] = '0;
    for (int a = 0; a < ROWS; a++) readRow(a, "R9 clear beats write");

    // R2: reload a new matrix
    setWeights(1);
    loadWeights(1);
    runBatch(4, 0, 4, 0, "R2 R4 new weights used");
    runBatch(4, 0, 0, 1, "R4 random after reload");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule